// File: doc/BRIEF.md
# Nested Interrupt Priority Save Stack

This block keeps the running priority level of an interrupt-handling processor and a small hidden stack of the levels that were preempted. When a new interrupt is acknowledged, the level in force is saved on the stack and the winning interrupt's level becomes the running level. When the handler signals end of interrupt, the most recently saved level is restored. Software therefore never has to save or restore the running level around nested handlers.

The store has 14 slots of 4 bits. This covers the 15 nesting levels that can occur, because a handler at level 15 cannot be preempted. The level that can be lost is the one at the bottom, which is always 0. On overflow the store acts as a ring and overwrites its oldest slot. A pop from an empty store yields 0, so the lost bottom level comes back. The stack has no address and no read or write path of its own.

Top module: `prio_nest_stack`

## Requirements
- R1: After reset the running level `curPrio` is 0 and the stack is empty, so a pop with no earlier push yields 0.
- R2: A push alone (`pushEn`=1, `popEn`=0) saves the running level on the stack. The cycle after the clock edge, `curPrio` equals the `newPrio` sampled at that edge.
- R3: A pop alone (`popEn`=1, `pushEn`=0) on a non-empty stack loads `curPrio` with the most recently saved level that has not been restored yet (last in, first out).
- R4: The stack holds 14 levels. Every push beyond 14 unrestored levels discards the oldest one. Later pops then return the 14 newest levels, newest first, and after them 0.
- R5: A pop alone on an empty stack sets `curPrio` to 0 and leaves the stack empty.
- R6: With neither strobe high, `curPrio` and the stack keep their values.
- R7: When push and pop are high in the same cycle, the push acts first and the pop second. `curPrio` keeps its value and the stored levels do not change, except that a full stack loses its oldest level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushEn | input | 1 | Acknowledge strobe: save the running level and take `newPrio` |
| popEn | input | 1 | End-of-interrupt strobe: restore the last saved level |
| newPrio | input | 4 | Level of the interrupt being acknowledged |
| curPrio | output | 4 | Running priority level |

## Verification
The assertions assume that each strobe is a clean one-cycle-per-event level, sampled at the rising edge. They also assume that `newPrio` is valid whenever `pushEn` is high. They accept any level from 0 to 15, including a push that does not raise the level. The stimulus changes all inputs only on the falling edge and draws `newPrio` over the whole 4-bit range. Long runs of pushes drive the stack past its full point, and long runs of pops drive it past empty. This puts the saturating occupancy at both of its limits while the properties watch it.

// File: rtl/prio_stack_pkg.sv
package prio_stack_pkg;

  // Strobes from the control half to the datapath half, one per cycle.
  typedef struct packed {
    logic saveCur;   // write running level into the slot at wrPtr
    logic loadNew;   // running level takes the acknowledged level
    logic loadTop;   // running level takes the top stored level
    logic loadZero;  // running level takes 0 (empty pop)
  } stackCtl_t;

endpackage

// File: rtl/prio_stack_ctrl.sv
module prio_stack_ctrl
  import prio_stack_pkg::*;
#(
  parameter int DEPTH = 14,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic             popEn,
  output stackCtl_t        ctl,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] topPtr,
  output logic [CNT_W-1:0] fillCount
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic isEmpty;
  logic isFull;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptrDec(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST_SLOT : p - 1'b1;
  endfunction

  assign isEmpty = (fillCount == '0);
  assign isFull  = (fillCount == FULL_CNT);
  assign topPtr  = ptrDec(wrPtr);

  always_comb begin
    ctl = '0;
    unique case ({pushEn, popEn})
      2'b10: begin
        ctl.saveCur = 1'b1;
        ctl.loadNew = 1'b1;
      end
      2'b01: begin
        if (isEmpty) ctl.loadZero = 1'b1;
        else         ctl.loadTop  = 1'b1;
      end
      default: ;  // idle, or push then pop which leaves the level as it was
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      fillCount <= '0;
    end else begin
      unique case ({pushEn, popEn})
        2'b10: begin
          wrPtr <= ptrInc(wrPtr);
          if (!isFull) fillCount <= fillCount + 1'b1;
        end
        2'b01: begin
          if (!isEmpty) begin
            wrPtr     <= topPtr;
            fillCount <= fillCount - 1'b1;
          end
        end
        2'b11: begin
          // the push would drop the oldest slot, the pop then removes the pushed one
          if (isFull) fillCount <= fillCount - 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/prio_stack_dp.sv
module prio_stack_dp
  import prio_stack_pkg::*;
#(
  parameter int DEPTH  = 14,
  parameter int PRIO_W = 4,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackCtl_t         ctl,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  topPtr,
  input  logic [PRIO_W-1:0] newPrio,
  output logic [PRIO_W-1:0] curPrio
);

  logic [PRIO_W-1:0] stash [DEPTH];
  logic [PRIO_W-1:0] topVal;

  assign topVal = stash[topPtr];

  always_ff @(posedge clk) begin
    if (ctl.saveCur) stash[wrPtr] <= curPrio;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPrio <= '0;
    end else begin
      if (ctl.loadNew)       curPrio <= newPrio;
      else if (ctl.loadTop)  curPrio <= topVal;
      else if (ctl.loadZero) curPrio <= '0;
    end
  end

endmodule

// File: rtl/prio_nest_stack.sv
module prio_nest_stack
  import prio_stack_pkg::*;
#(
  parameter int DEPTH  = 14,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushEn,
  input  logic              popEn,
  input  logic [PRIO_W-1:0] newPrio,
  output logic [PRIO_W-1:0] curPrio
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  stackCtl_t        ctl;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] topPtr;
  logic [CNT_W-1:0] fillCount;

  prio_stack_ctrl #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pushEn    (pushEn),
    .popEn     (popEn),
    .ctl       (ctl),
    .wrPtr     (wrPtr),
    .topPtr    (topPtr),
    .fillCount (fillCount)
  );

  prio_stack_dp #(
    .DEPTH  (DEPTH),
    .PRIO_W (PRIO_W),
    .PTR_W  (PTR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrPtr   (wrPtr),
    .topPtr  (topPtr),
    .newPrio (newPrio),
    .curPrio (curPrio)
  );

endmodule

// File: rtl/prio_nest_stack_chk.sv
module prio_nest_stack_chk #(
  parameter int DEPTH  = 14,
  parameter int PRIO_W = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushEn,
  input logic              popEn,
  input logic [PRIO_W-1:0] newPrio,
  input logic [PRIO_W-1:0] curPrio,
  input logic [CNT_W-1:0]  fillCount
);

  // R2: a lone push makes the acknowledged level the running level
  a_r2_push_takes_new: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn) |=> (curPrio == $past(newPrio)));

  // R4: occupancy stays at the full mark when a full stack is pushed
  a_r4_full_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn && fillCount == CNT_W'(DEPTH)) |=> (fillCount == CNT_W'(DEPTH)));

  // R4: occupancy never exceeds the number of slots
  a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  // R5: a lone pop of an empty stack gives level 0 and keeps it empty
  a_r5_empty_pop_zero: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && fillCount == '0) |=> (curPrio == '0 && fillCount == '0));

  // R3: a lone pop of a non-empty stack lowers the occupancy by one
  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && fillCount != '0) |=> (fillCount == $past(fillCount) - 1'b1));

  // R6: no strobe, no change
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!pushEn && !popEn) |=> ($stable(curPrio) && $stable(fillCount)));

  // R7: push with pop in one cycle leaves the running level alone
  a_r7_both_keeps_level: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn) |=> $stable(curPrio));

endmodule

bind prio_nest_stack prio_nest_stack_chk #(
  .DEPTH  (DEPTH),
  .PRIO_W (PRIO_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pushEn    (pushEn),
  .popEn     (popEn),
  .newPrio   (newPrio),
  .curPrio   (curPrio),
  .fillCount (fillCount)
);

// File: tb/prio_nest_stack_bench.sv
module prio_nest_stack_bench;

  localparam int SLOTS = 14;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pushEn = 1'b0;
  logic       popEn = 1'b0;
  logic [3:0] newPrio = '0;
  logic [3:0] curPrio;

  int total = 0;
  int bad = 0;

  logic [3:0] saved[$];
  logic [3:0] expPrio = '0;

  always #10 clk = ~clk;  // 50 MHz

  prio_nest_stack u_prio_nest_stack (
    .clk     (clk),
    .rstN    (rstN),
    .pushEn  (pushEn),
    .popEn   (popEn),
    .newPrio (newPrio),
    .curPrio (curPrio)
  );

  // reference: push first, then pop, on a ring that keeps the newest SLOTS levels
  function automatic void modelStep(input logic p, input logic q, input logic [3:0] np);
    if (p) begin
      saved.push_back(expPrio);
      if (saved.size() > SLOTS) void'(saved.pop_front());
      expPrio = np;
    end
    if (q) begin
      if (saved.size() > 0) expPrio = saved.pop_back();
      else                  expPrio = 4'd0;
    end
  endfunction

  function automatic string pickTag(input logic p, input logic q, input int depthBefore);
    if (p && q)        return "R7";
    if (p)             return "R2";
    if (q)             return (depthBefore == 0) ? "R5" : "R3";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [3:0] exp);
    total++;
    if (curPrio !== exp) begin
      bad++;
      $display("FAIL %s: curPrio=%0d expected=%0d", tag, curPrio, exp);
    end
  endtask

  // called at a falling edge; drives one cycle and checks at the next falling edge
  task automatic cycle(input logic p, input logic q, input logic [3:0] np, input string tagOvr);
    string tag;
    tag = (tagOvr != "") ? tagOvr : pickTag(p, q, saved.size());
    pushEn  = p;
    popEn   = q;
    newPrio = np;
    modelStep(p, q, np);
    @(negedge clk);
    check(tag, expPrio);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: curPrio=%0d expected=%0d", curPrio, expPrio);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 4'd0);

    // R1/R5: pop straight after reset
    cycle(1'b0, 1'b1, 4'd0, "R1");
    cycle(1'b0, 1'b1, 4'd0, "R5");
    cycle(1'b0, 1'b0, 4'd0, "R6");

    // R4: push 20 distinct-ish levels, then pop well past empty
    for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0, 4'((i % 15) + 1), "R2");
    for (int i = 0; i < 18; i++) cycle(1'b0, 1'b1, 4'd0, "R4");

    // R7: same-cycle push/pop on a full stack drops the oldest level
    for (int i = 0; i < 16; i++) cycle(1'b1, 1'b0, 4'(15 - (i % 15)), "R2");
    cycle(1'b1, 1'b1, 4'd9, "R7");
    for (int i = 0; i < 16; i++) cycle(1'b0, 1'b1, 4'd0, "R7");

    // R7 on an empty stack
    cycle(1'b1, 1'b1, 4'd5, "R7");
    cycle(1'b0, 1'b1, 4'd0, "R5");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic p, q;
      r = int'($urandom_range(0, 99));
      p = (r < 40) || (r >= 85 && r < 95);
      q = (r >= 40 && r < 75) || (r >= 85 && r < 95);
      cycle(p, q, 4'($urandom_range(0, 15)), "");
    end

    // drain and confirm bottom returns to 0
    for (int i = 0; i < 16; i++) cycle(1'b0, 1'b1, 4'd0, "");
    cycle(1'b0, 1'b0, 4'd0, "R6");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule